// File: doc/BRIEF.md
# Supervisor Timer Compare CSR Unit

This unit sits beside the CSR file of a hart that has supervisor and hypervisor modes. It holds two 64-bit timer compare registers. One serves the supervisor and one serves a guest running in virtual-supervisor mode. It also holds the two timer-compare enable bits, one in the machine environment-configuration register and one in the hypervisor environment-configuration register. From these it produces the supervisor timer pending level (STIP) and the virtual-supervisor timer pending level (VSTIP).

Each pending level works in one of two modes. In legacy mode the level is a bit that software writes. In compare mode the level is read-only and is driven by an unsigned compare of the time base against the matching compare register. The guest lane adds a 64-bit guest time offset to the time base before it compares. The two enable bits select the mode of each lane. The machine-level bit gates both lanes, and the hypervisor-level bit also gates the guest lane.

The pipeline presents one CSR request per cycle with the current privilege and virtualization bit. One cycle later the unit returns the read data, or raises an illegal-instruction flag or a virtual-instruction flag. A request that traps changes no state.

Top module: `stc_csr_unit`

## Requirements
- R1: Out of reset both compare registers are all-ones, both enable bits are 0, and stip_o, vstip_o, illegal_o, virtual_o and rdata_o are 0.
- R2: A request with privilege M (2'b11) to any of the four addresses never raises a flag. Its read data appears on rdata_o in the cycle after the request, whatever the enable bits hold.
- R3: While the machine enable is 0, a non-M request to the supervisor compare (0x14D) or the guest compare (0x24D) raises illegal_o and not virtual_o, for either value of V, and leaves both registers unchanged.
- R4: While the machine enable is 0, the hypervisor enable (bit 63 of 0x60A) reads 0 and writes to it are dropped. It still reads 0 after the machine enable (bit 63 of 0x30A) is set again.
- R5: While the machine enable is 0, stip_o follows the software pending bit, which is loaded through stip_we_i and stip_wdata_i.
- R6: While the machine enable is 1, stip_o is 1 exactly when time_i >= supervisor compare, compared unsigned. Software pending writes are ignored.
- R7: While the machine enable is 1 and the hypervisor enable is 0, a request to 0x14D with V=1 raises virtual_o and not illegal_o.
- R8: While the machine enable is 1 and the hypervisor enable is 0, vstip_o follows the software guest pending bit, which is loaded through vstip_we_i and vstip_wdata_i.
- R9: While both enables are 1, vstip_o is 1 exactly when (time_i + guest_off_i) mod 2^64 >= guest compare, compared unsigned. Software guest pending writes are ignored.
- R10: With V=1 and privilege S (2'b01), and both enables 1, a read or write of 0x14D reaches the guest compare and leaves the supervisor compare unchanged.
- R11: Privilege U (2'b00) with V=0 gets illegal_o on 0x14D. A non-M request to 0x30A gets illegal_o. A request with V=1 to 0x60A gets virtual_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | Free-running time base |
| guest_off_i | input | 64 | Offset added to the time base for the guest compare |
| req_valid_i | input | 1 | CSR request present this cycle |
| req_addr_i | input | 12 | CSR address |
| req_we_i | input | 1 | Request writes req_wdata_i |
| req_wdata_i | input | 64 | Write data |
| req_priv_i | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| req_virt_i | input | 1 | Virtualization bit V |
| stip_we_i | input | 1 | Software write of the supervisor pending bit |
| stip_wdata_i | input | 1 | Value for the supervisor pending bit |
| vstip_we_i | input | 1 | Software write of the guest pending bit |
| vstip_wdata_i | input | 1 | Value for the guest pending bit |
| rdata_o | output | 64 | Read data, one cycle after the request (old value on a write) |
| illegal_o | output | 1 | Illegal-instruction flag for the previous request |
| virtual_o | output | 1 | Virtual-instruction flag for the previous request |
| stip_o | output | 1 | Supervisor timer pending level |
| vstip_o | output | 1 | Guest timer pending level |

## Verification
The hardest case to reach from the ports is a software pending write that arrives while its lane is in compare mode. That write must leave no trace. The only way to see the hidden bit is to change the enables afterwards, so the stimulus writes the pending bit while the compare holds the level at 0. It then drops the enable and checks that the legacy level is still the old value. Unsigned compares and the wrap of the guest sum are reached by loading the compare with the top bit set and by using an offset of all-ones.

// File: rtl/stc_pkg.sv
package stc_pkg;

    localparam int CSR_AW = 12;

    localparam logic [CSR_AW-1:0] ADDR_SCMP = 12'h14D;
    localparam logic [CSR_AW-1:0] ADDR_VCMP = 12'h24D;
    localparam logic [CSR_AW-1:0] ADDR_MENV = 12'h30A;
    localparam logic [CSR_AW-1:0] ADDR_HENV = 12'h60A;

    typedef enum logic [1:0] {
        PRIV_U = 2'b00,
        PRIV_S = 2'b01,
        PRIV_M = 2'b11
    } priv_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_SCMP,
        TGT_VCMP,
        TGT_MENV,
        TGT_HENV
    } tgt_e;

    typedef struct packed {
        tgt_e tgt;
        logic illegal;
        logic virt;
    } acc_t;

endpackage

// File: rtl/stc_access_check.sv
module stc_access_check
    import stc_pkg::*;
(
    input  logic [CSR_AW-1:0] addr_i,
    input  logic [1:0]        priv_i,
    input  logic              virt_i,
    input  logic              m_en_i,
    input  logic              h_en_i,
    output acc_t              acc_o
);

    logic is_m;
    logic is_u;

    assign is_m = (priv_i == PRIV_M);
    assign is_u = (priv_i == PRIV_U);

    always_comb begin
        acc_o.tgt     = TGT_NONE;
        acc_o.illegal = 1'b0;
        acc_o.virt    = 1'b0;
        case (addr_i)
            ADDR_SCMP: begin
                if (is_m)           acc_o.tgt     = TGT_SCMP;
                else if (!m_en_i)   acc_o.illegal = 1'b1;
                else if (virt_i) begin
                    if (is_u || !h_en_i) acc_o.virt = 1'b1;
                    else                 acc_o.tgt  = TGT_VCMP;
                end
                else if (is_u)      acc_o.illegal = 1'b1;
                else                acc_o.tgt     = TGT_SCMP;
            end
            ADDR_VCMP: begin
                if (is_m)           acc_o.tgt     = TGT_VCMP;
                else if (!m_en_i)   acc_o.illegal = 1'b1;
                else if (virt_i)    acc_o.virt    = 1'b1;
                else if (is_u)      acc_o.illegal = 1'b1;
                else                acc_o.tgt     = TGT_VCMP;
            end
            ADDR_MENV: begin
                if (is_m)           acc_o.tgt     = TGT_MENV;
                else                acc_o.illegal = 1'b1;
            end
            ADDR_HENV: begin
                if (is_m)           acc_o.tgt     = TGT_HENV;
                else if (virt_i)    acc_o.virt    = 1'b1;
                else if (is_u)      acc_o.illegal = 1'b1;
                else                acc_o.tgt     = TGT_HENV;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stc_compare.sv
module stc_compare #(
    parameter int W = 64
) (
    input  logic [W-1:0] now_i,
    input  logic [W-1:0] off_i,
    input  logic [W-1:0] cmp_i,
    output logic         fire_o
);

    logic [W-1:0] shifted;

    assign shifted = now_i + off_i;
    assign fire_o  = (shifted >= cmp_i);

endmodule

// File: rtl/stc_csr_unit.sv
module stc_csr_unit
    import stc_pkg::*;
#(
    parameter int TW       = 64,
    parameter int STCE_BIT = 63
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [TW-1:0]     time_i,
    input  logic [TW-1:0]     guest_off_i,
    input  logic              req_valid_i,
    input  logic [CSR_AW-1:0] req_addr_i,
    input  logic              req_we_i,
    input  logic [TW-1:0]     req_wdata_i,
    input  logic [1:0]        req_priv_i,
    input  logic              req_virt_i,
    input  logic              stip_we_i,
    input  logic              stip_wdata_i,
    input  logic              vstip_we_i,
    input  logic              vstip_wdata_i,
    output logic [TW-1:0]     rdata_o,
    output logic              illegal_o,
    output logic              virtual_o,
    output logic              stip_o,
    output logic              vstip_o
);

    localparam int LANES  = 2;
    localparam int LANE_S = 0;
    localparam int LANE_V = 1;

    typedef struct packed {
        logic [TW-1:0] scmp;
        logic [TW-1:0] vcmp;
        logic [TW-1:0] rdata;
        logic          m_en;
        logic          h_en;
        logic          sw_stip;
        logic          sw_vstip;
        logic          stip;
        logic          vstip;
        logic          ill;
        logic          vi;
    } st_t;

    localparam st_t RST_ST = '{
        scmp:     {TW{1'b1}},
        vcmp:     {TW{1'b1}},
        rdata:    '0,
        m_en:     1'b0,
        h_en:     1'b0,
        sw_stip:  1'b0,
        sw_vstip: 1'b0,
        stip:     1'b0,
        vstip:    1'b0,
        ill:      1'b0,
        vi:       1'b0
    };

    st_t  st_q;
    st_t  st_d;
    acc_t acc;

    logic [TW-1:0]    lane_cmp [LANES];
    logic [TW-1:0]    lane_off [LANES];
    logic [LANES-1:0] lane_fire;

    stc_access_check u_acc (
        .addr_i (req_addr_i),
        .priv_i (req_priv_i),
        .virt_i (req_virt_i),
        .m_en_i (st_q.m_en),
        .h_en_i (st_q.h_en),
        .acc_o  (acc)
    );

    assign lane_cmp[LANE_S] = st_q.scmp;
    assign lane_off[LANE_S] = '0;
    assign lane_cmp[LANE_V] = st_q.vcmp;
    assign lane_off[LANE_V] = guest_off_i;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        stc_compare #(.W(TW)) u_cmp (
            .now_i  (time_i),
            .off_i  (lane_off[g]),
            .cmp_i  (lane_cmp[g]),
            .fire_o (lane_fire[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.ill   = 1'b0;
        st_d.vi    = 1'b0;

        if (req_valid_i) begin
            st_d.ill = acc.illegal;
            st_d.vi  = acc.virt;
            case (acc.tgt)
                TGT_SCMP: begin
                    st_d.rdata = st_q.scmp;
                    if (req_we_i) st_d.scmp = req_wdata_i;
                end
                TGT_VCMP: begin
                    st_d.rdata = st_q.vcmp;
                    if (req_we_i) st_d.vcmp = req_wdata_i;
                end
                TGT_MENV: begin
                    st_d.rdata[STCE_BIT] = st_q.m_en;
                    if (req_we_i) st_d.m_en = req_wdata_i[STCE_BIT];
                end
                TGT_HENV: begin
                    st_d.rdata[STCE_BIT] = st_q.h_en;
                    if (req_we_i && st_q.m_en) st_d.h_en = req_wdata_i[STCE_BIT];
                end
                default: ;
            endcase
        end

        // the guest enable cannot outlive the machine enable
        if (!st_d.m_en) st_d.h_en = 1'b0;

        if (stip_we_i && !st_q.m_en)
            st_d.sw_stip = stip_wdata_i;
        if (vstip_we_i && !(st_q.m_en && st_q.h_en))
            st_d.sw_vstip = vstip_wdata_i;

        st_d.stip  = st_q.m_en ? lane_fire[LANE_S] : st_q.sw_stip;
        st_d.vstip = (st_q.m_en && st_q.h_en) ? lane_fire[LANE_V] : st_q.sw_vstip;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= RST_ST;
        else         st_q <= st_d;
    end

    assign rdata_o   = st_q.rdata;
    assign illegal_o = st_q.ill;
    assign virtual_o = st_q.vi;
    assign stip_o    = st_q.stip;
    assign vstip_o   = st_q.vstip;

endmodule

// File: rtl/stc_csr_sva.sv
module stc_csr_sva
    import stc_pkg::*;
#(
    parameter int TW       = 64,
    parameter int STCE_BIT = 63
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [TW-1:0]     time_i,
    input logic [TW-1:0]     guest_off_i,
    input logic              req_valid_i,
    input logic [CSR_AW-1:0] req_addr_i,
    input logic [1:0]        req_priv_i,
    input logic              req_virt_i,
    input logic              req_we_i,
    input logic [TW-1:0]     rdata_o,
    input logic              illegal_o,
    input logic              virtual_o,
    input logic              stip_o,
    input logic              vstip_o,
    input logic              m_en,
    input logic              h_en,
    input logic [TW-1:0]     scmp,
    input logic [TW-1:0]     vcmp
);

    logic [TW-1:0] gtime;
    logic          timer_addr;
    logic          henv_read;

    assign gtime      = time_i + guest_off_i;
    assign timer_addr = (req_addr_i == ADDR_SCMP) || (req_addr_i == ADDR_VCMP);
    assign henv_read  = req_valid_i && !req_we_i && (req_addr_i == ADDR_HENV)
                        && (req_priv_i == PRIV_M);

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(illegal_o && virtual_o)); // R7

    AST_FLAG_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (illegal_o || virtual_o) |-> $past(req_valid_i)); // R11

    AST_M_NEVER_TRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_priv_i == PRIV_M) |=> (!illegal_o && !virtual_o)); // R2

    AST_MOFF_ILLEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_priv_i != PRIV_M && timer_addr && !m_en)
        |=> (illegal_o && !virtual_o)); // R3

    AST_HEN_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (henv_read && !m_en) |=> !rdata_o[STCE_BIT]); // R4

    AST_STIP_COMPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        m_en |=> (stip_o == ($past(time_i) >= $past(scmp)))); // R6

    AST_VIRT_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_priv_i != PRIV_M && req_virt_i
         && req_addr_i == ADDR_SCMP && m_en && !h_en)
        |=> (virtual_o && !illegal_o)); // R7

    AST_VSTIP_COMPARE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_en && h_en) |=> (vstip_o == ($past(gtime) >= $past(vcmp)))); // R9

endmodule

bind stc_csr_unit stc_csr_sva #(.TW(TW), .STCE_BIT(STCE_BIT)) u_sva (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .time_i      (time_i),
    .guest_off_i (guest_off_i),
    .req_valid_i (req_valid_i),
    .req_addr_i  (req_addr_i),
    .req_priv_i  (req_priv_i),
    .req_virt_i  (req_virt_i),
    .req_we_i    (req_we_i),
    .rdata_o     (rdata_o),
    .illegal_o   (illegal_o),
    .virtual_o   (virtual_o),
    .stip_o      (stip_o),
    .vstip_o     (vstip_o),
    .m_en        (st_q.m_en),
    .h_en        (st_q.h_en),
    .scmp        (st_q.scmp),
    .vcmp        (st_q.vcmp)
);

// File: tb/tb_stc_csr_unit.sv
module tb_stc_csr_unit;
    import stc_pkg::*;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] EN   = 64'h8000_0000_0000_0000;
    localparam logic [1:0]  PM = 2'b11, PS = 2'b01, PU = 2'b00;
    localparam int NV = 20;

    typedef struct packed {
        logic [1:0]  priv;
        logic        virt;
        logic [11:0] addr;
        logic        we;
        logic [63:0] wd;
        logic        ill;
        logic        vi;
        logic [63:0] rd;
        logic [7:0]  req;
    } vec_t;

    // walked in order from reset; each entry assumes the state left by the previous ones
    localparam vec_t VECS [NV] = '{
        '{PM, 1'b0, ADDR_SCMP, 1'b0, 64'h0,   1'b0, 1'b0, ONES,  8'd1},  // R1 R2
        '{PS, 1'b0, ADDR_SCMP, 1'b0, 64'h0,   1'b1, 1'b0, 64'h0, 8'd3},  // R3
        '{PS, 1'b0, ADDR_VCMP, 1'b1, 64'h55,  1'b1, 1'b0, 64'h0, 8'd3},  // R3
        '{PM, 1'b0, ADDR_HENV, 1'b1, EN,      1'b0, 1'b0, 64'h0, 8'd4},  // R4
        '{PM, 1'b0, ADDR_HENV, 1'b0, 64'h0,   1'b0, 1'b0, 64'h0, 8'd4},  // R4
        '{PM, 1'b0, ADDR_VCMP, 1'b0, 64'h0,   1'b0, 1'b0, ONES,  8'd3},  // R3
        '{PM, 1'b0, ADDR_MENV, 1'b1, EN,      1'b0, 1'b0, 64'h0, 8'd2},  // R2
        '{PM, 1'b0, ADDR_HENV, 1'b0, 64'h0,   1'b0, 1'b0, 64'h0, 8'd4},  // R4
        '{PS, 1'b1, ADDR_SCMP, 1'b0, 64'h0,   1'b0, 1'b1, 64'h0, 8'd7},  // R7
        '{PU, 1'b0, ADDR_SCMP, 1'b0, 64'h0,   1'b1, 1'b0, 64'h0, 8'd11}, // R11
        '{PS, 1'b0, ADDR_MENV, 1'b0, 64'h0,   1'b1, 1'b0, 64'h0, 8'd11}, // R11
        '{PS, 1'b0, ADDR_SCMP, 1'b1, 64'h100, 1'b0, 1'b0, ONES,  8'd6},  // R6
        '{PS, 1'b0, ADDR_SCMP, 1'b0, 64'h0,   1'b0, 1'b0, 64'h100, 8'd6},
        '{PS, 1'b0, ADDR_HENV, 1'b1, EN,      1'b0, 1'b0, 64'h0, 8'd11}, // R11
        '{PS, 1'b1, ADDR_SCMP, 1'b1, 64'h200, 1'b0, 1'b0, ONES,  8'd10}, // R10
        '{PM, 1'b0, ADDR_VCMP, 1'b0, 64'h0,   1'b0, 1'b0, 64'h200, 8'd10},
        '{PM, 1'b0, ADDR_SCMP, 1'b0, 64'h0,   1'b0, 1'b0, 64'h100, 8'd10},
        '{PS, 1'b1, ADDR_SCMP, 1'b0, 64'h0,   1'b0, 1'b0, 64'h200, 8'd10},
        '{PS, 1'b1, ADDR_HENV, 1'b0, 64'h0,   1'b0, 1'b1, 64'h0, 8'd11},
        '{PM, 1'b0, ADDR_MENV, 1'b0, 64'h0,   1'b0, 1'b0, EN,    8'd2}
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [63:0] time_i = '0;
    logic [63:0] guest_off_i = '0;
    logic        req_valid_i = 1'b0;
    logic [11:0] req_addr_i = '0;
    logic        req_we_i = 1'b0;
    logic [63:0] req_wdata_i = '0;
    logic [1:0]  req_priv_i = 2'b11;
    logic        req_virt_i = 1'b0;
    logic        stip_we_i = 1'b0;
    logic        stip_wdata_i = 1'b0;
    logic        vstip_we_i = 1'b0;
    logic        vstip_wdata_i = 1'b0;
    logic [63:0] rdata_o;
    logic        illegal_o;
    logic        virtual_o;
    logic        stip_o;
    logic        vstip_o;

    int checks = 0;
    int errors = 0;

    always #2 clk_i = ~clk_i;

    stc_csr_unit dut (
        .clk_i, .rst_ni, .time_i, .guest_off_i,
        .req_valid_i, .req_addr_i, .req_we_i, .req_wdata_i,
        .req_priv_i, .req_virt_i,
        .stip_we_i, .stip_wdata_i, .vstip_we_i, .vstip_wdata_i,
        .rdata_o, .illegal_o, .virtual_o, .stip_o, .vstip_o
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [1:0] priv, input logic virt,
                          input logic [11:0] addr, input logic we,
                          input logic [63:0] wd);
        @(negedge clk_i);
        req_valid_i = 1'b1;
        req_priv_i  = priv;
        req_virt_i  = virt;
        req_addr_i  = addr;
        req_we_i    = we;
        req_wdata_i = wd;
        @(negedge clk_i);
        req_valid_i = 1'b0;
        req_we_i    = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk_i);
    endtask

    task automatic sw_pend(input logic lane_v, input logic val);
        @(negedge clk_i);
        if (lane_v) begin vstip_we_i = 1'b1; vstip_wdata_i = val; end
        else        begin stip_we_i  = 1'b1; stip_wdata_i  = val; end
        @(negedge clk_i);
        stip_we_i  = 1'b0;
        vstip_we_i = 1'b0;
        settle();
    endtask

    task automatic set_time(input logic [63:0] t);
        @(negedge clk_i);
        time_i = t;
        settle();
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1 reset state
        check("R1", "stip", {63'd0, stip_o}, 64'd0);
        check("R1", "vstip", {63'd0, vstip_o}, 64'd0);
        check("R1", "flags", {62'd0, illegal_o, virtual_o}, 64'd0);
        check("R1", "rdata", rdata_o, 64'd0);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            do_req(VECS[i].priv, VECS[i].virt, VECS[i].addr, VECS[i].we, VECS[i].wd);
            check(tag, "illegal", {63'd0, illegal_o}, {63'd0, VECS[i].ill});
            check(tag, "virtual", {63'd0, virtual_o}, {63'd0, VECS[i].vi});
            check(tag, "rdata", rdata_o, VECS[i].rd);
        end

        // state now: both enables 1, supervisor compare 0x100, guest compare 0x200
        set_time(64'hFF);
        check("R6", "below", {63'd0, stip_o}, 64'd0);
        sw_pend(1'b0, 1'b1);
        check("R6", "sw write ignored", {63'd0, stip_o}, 64'd0);
        set_time(64'h100);
        check("R6", "equal", {63'd0, stip_o}, 64'd1);

        do_req(PM, 1'b0, ADDR_SCMP, 1'b1, EN);
        set_time(64'h7FFF_FFFF_FFFF_FFFF);
        check("R6", "unsigned below", {63'd0, stip_o}, 64'd0);
        set_time(64'h8000_0000_0000_0000);
        check("R6", "unsigned equal", {63'd0, stip_o}, 64'd1);

        @(negedge clk_i) guest_off_i = 64'h50;
        set_time(64'h1AF);
        check("R9", "offset below", {63'd0, vstip_o}, 64'd0);
        set_time(64'h1B0);
        check("R9", "offset equal", {63'd0, vstip_o}, 64'd1);
        @(negedge clk_i) guest_off_i = ONES;
        set_time(64'h200);
        check("R9", "wrapped below", {63'd0, vstip_o}, 64'd0);
        set_time(64'h201);
        check("R9", "wrapped equal", {63'd0, vstip_o}, 64'd1);
        set_time(64'h200);
        sw_pend(1'b1, 1'b1);
        check("R9", "sw write ignored", {63'd0, vstip_o}, 64'd0);

        do_req(PM, 1'b0, ADDR_HENV, 1'b1, 64'h0);
        settle();
        check("R8", "legacy keeps old bit", {63'd0, vstip_o}, 64'd0);
        sw_pend(1'b1, 1'b1);
        check("R8", "legacy sw set", {63'd0, vstip_o}, 64'd1);
        check("R6", "still compare", {63'd0, stip_o}, 64'd0);
        do_req(PS, 1'b1, ADDR_SCMP, 1'b0, 64'h0);
        check("R7", "virtual", {62'd0, illegal_o, virtual_o}, 64'd1);

        do_req(PM, 1'b0, ADDR_MENV, 1'b1, 64'h0);
        settle();
        check("R5", "legacy keeps old bit", {63'd0, stip_o}, 64'd0);
        sw_pend(1'b0, 1'b1);
        check("R5", "sw set", {63'd0, stip_o}, 64'd1);
        sw_pend(1'b0, 1'b0);
        check("R5", "sw clear", {63'd0, stip_o}, 64'd0);
        check("R8", "guest legacy held", {63'd0, vstip_o}, 64'd1);

        do_req(PS, 1'b1, ADDR_SCMP, 1'b1, 64'h33);
        check("R3", "V=1 illegal", {62'd0, illegal_o, virtual_o}, 64'd2);
        do_req(PU, 1'b1, ADDR_VCMP, 1'b0, 64'h0);
        check("R3", "VU illegal", {62'd0, illegal_o, virtual_o}, 64'd2);
        do_req(PM, 1'b0, ADDR_SCMP, 1'b0, 64'h0);
        check("R3", "stimecmp unchanged", rdata_o, EN);
        do_req(PM, 1'b0, ADDR_VCMP, 1'b0, 64'h0);
        check("R2", "M read guest", rdata_o, 64'h200);

        do_req(PM, 1'b0, ADDR_HENV, 1'b1, EN);
        do_req(PM, 1'b0, ADDR_HENV, 1'b0, 64'h0);
        check("R4", "read zero", rdata_o, 64'h0);
        do_req(PM, 1'b0, ADDR_MENV, 1'b1, EN);
        do_req(PM, 1'b0, ADDR_HENV, 1'b0, 64'h0);
        check("R4", "dropped write", rdata_o, 64'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule